// File: doc/BRIEF.md
# Oversampled Command Frame Receiver

This block turns a demodulated, oversampled serial line into command bytes. A strobe marks each clock in which the line holds a valid sample, and a fixed number of samples (four by default) makes up one bit period. The receiver stays idle until the line falls. It then measures how many low bit periods follow. A low run of acceptable length, ended by a rise, opens a frame.

Inside a frame the block collects asynchronous-style characters. Each character is a low start bit, the data bits least significant first, and a high stop bit. Every well-framed character is handed out as a byte with a one-clock valid strobe, and a running byte count is kept. A character made entirely of zero bits closes the frame. Overlong idle gaps between characters, badly framed characters and running into the byte limit all abort the frame with a one-clock error pulse.

The outputs are registered. A pulse appears one clock after the enabled sample that caused it, and the byte count stays readable after the frame ends until the next frame start clears it.

Top module: `ovs_frame_rx`

## Requirements
- R1: While reset is held and right after it, `in_frame`, `byte_valid`, `frame_done` and `frame_err` are 0 and `byte_count` is 0.
- R2: The line is looked at only in clocks where `smp_en` is 1. In the clock after a cycle with `smp_en` at 0, no pulse is raised and `in_frame` and `byte_count` are unchanged.
- R3: Each bit spans OSR=4 enabled samples, numbered 0 to 3 from the edge that started the character or the start-of-frame check. The bit value is the sample at position 2; the other three samples have no effect on the received data.
- R4: From idle, a low sample begins a start-of-frame check. A high bit value seen after 10 to 12 low bit values accepts the frame: `in_frame` goes to 1 and `byte_count` is cleared to 0.
- R5: A high bit value seen after fewer than 10 low bit values returns the block to idle, with no error pulse and without raising `in_frame`.
- R6: When a 13th low bit value arrives during the check, the block returns to idle, with no error pulse and without raising `in_frame`.
- R7: While a start bit is awaited, up to 25 consecutive high samples are tolerated. The 26th high sample aborts: `frame_err` pulses and `in_frame` drops.
- R8: A character is 10 bits: bit 0 is the start bit and must be 0, bits 1 to 8 carry data LSB first, and bit 9 is the stop bit and must be 1. A good character pulses `byte_valid` with the data on `byte_data` and increments `byte_count`.
- R9: A character with all ten bits 0 ends the frame and drops `in_frame`. `frame_done` pulses only if `byte_count` is nonzero; with zero bytes there is neither a done pulse nor an error pulse.
- R10: Any other character that is neither well framed nor all zero pulses `frame_err` and drops `in_frame`.
- R11: The byte that brings `byte_count` to MAX_BYTES is still delivered with `byte_valid`. In the same clock `frame_err` pulses and the frame ends, so `byte_count` never exceeds MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Qualifies `rx_bit` as a valid line sample in this clock |
| rx_bit | input | 1 | Demodulated line level |
| byte_data | output | DATA_W | Last received data byte |
| byte_valid | output | 1 | One-clock strobe: `byte_data` holds a new byte |
| byte_count | output | CNT_W | Bytes received in the current or last frame |
| frame_done | output | 1 | One-clock pulse: frame closed by an end character after at least one byte |
| frame_err | output | 1 | One-clock pulse: frame aborted |
| in_frame | output | 1 | High between an accepted frame start and its end or abort |

## Verification
The bench builds the receiver with MAX_BYTES set to 3 and keeps the default oversampling, frame-start limits and gap limit. The small byte limit lets a three-byte frame reach the limit abort. The default timing parameters let directed frames hit both ends of the accepted frame-start window (10 and 12 low bits), one bit on either side of it, and the gap limit at 25 and at more than 25 idle samples. Between enabled samples the bench drives the inverse of the line value, and inside one character it inverts every sample except position 2. Together these show that only the strobed mid-bit sample decides the data.

// File: rtl/ovs_frame_rx_pkg.sv
package ovs_frame_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_SOF  = 2'd1,
      RX_GAP  = 2'd2,
      RX_CHAR = 2'd3
   } rx_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ovs_phase_ctr.sv
// Position of the current sample within one bit period; flags the decision sample.
module ovs_phase_ctr #(
   parameter int OSR        = 4,
   parameter int SAMPLE_POS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic mid
);
   localparam int W = (OSR > 2) ? $clog2(OSR) : 1;

   logic [W-1:0] pos_q;
   logic [W-1:0] pos_wrap;
   logic [W:0]   pos_inc;

   assign pos_inc = {1'b0, pos_q} + (W+1)'(1);
   assign mid     = adv && (pos_inc == (W+1)'(SAMPLE_POS));

   generate
      if ((OSR & (OSR - 1)) == 0) begin : g_pow2
         assign pos_wrap = pos_inc[W-1:0];
      end else begin : g_cmp
         assign pos_wrap = (pos_inc >= (W+1)'(OSR)) ? '0 : pos_inc[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pos_q <= '0;
      else if (clr) pos_q <= '0;
      else if (adv) pos_q <= pos_wrap;
   end
endmodule

// File: rtl/ovs_sat_ctr.sv
// Clearable up-counter that sticks at its top value.
module ovs_sat_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= '0;
      else if (clr)               q <= '0;
      else if (inc && (q != '1))  q <= q + W'(1);
   end
endmodule

// File: rtl/ovs_char_shift.sv
// Character register: new bit enters at the top, older bits move toward bit 0.
module ovs_char_shift #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic         din,
   output logic [N-1:0] word_nxt
);
   logic [N-1:0] word_q;

   assign word_nxt = {din, word_q[N-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (clr)   word_q <= '0;
      else if (shift) word_q <= word_nxt;
   end
endmodule

// File: rtl/ovs_frame_rx.sv
module ovs_frame_rx
   import ovs_frame_rx_pkg::*;
#(
   parameter int OSR          = 4,
   parameter int SAMPLE_POS   = 2,
   parameter int DATA_W       = 8,
   parameter int SOF_MIN_BITS = 10,
   parameter int SOF_MAX_BITS = 12,
   parameter int GAP_MAX      = 25,
   parameter int MAX_BYTES    = 16,
   parameter int CNT_W        = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_en,
   input  logic              rx_bit,
   output logic [DATA_W-1:0] byte_data,
   output logic              byte_valid,
   output logic [CNT_W-1:0]  byte_count,
   output logic              frame_done,
   output logic              frame_err,
   output logic              in_frame
);
   localparam int CHAR_BITS = DATA_W + 2;
   localparam int BIT_LIM   = imax(SOF_MAX_BITS + 1, CHAR_BITS);
   localparam int BIT_W     = $clog2(BIT_LIM + 1);
   localparam int GAP_W     = $clog2(GAP_MAX + 2);

   localparam logic [BIT_W:0] SOF_MIN_C  = (BIT_W+1)'(SOF_MIN_BITS);
   localparam logic [BIT_W:0] SOF_MAX_C  = (BIT_W+1)'(SOF_MAX_BITS);
   localparam logic [BIT_W:0] CHAR_C     = (BIT_W+1)'(CHAR_BITS);
   localparam logic [GAP_W:0] GAP_MAX_C  = (GAP_W+1)'(GAP_MAX);
   localparam logic [CNT_W:0] MAX_BYTE_C = (CNT_W+1)'(MAX_BYTES);

   // elaboration-time parameter checks
   generate
      if (OSR < 2) begin : g_bad_osr
         $error("ovs_frame_rx: OSR must be at least 2");
      end
      if (SAMPLE_POS < 1 || SAMPLE_POS >= OSR) begin : g_bad_pos
         $error("ovs_frame_rx: SAMPLE_POS must lie in 1..OSR-1");
      end
      if (SOF_MIN_BITS < 1 || SOF_MAX_BITS < SOF_MIN_BITS) begin : g_bad_sof
         $error("ovs_frame_rx: need 1 <= SOF_MIN_BITS <= SOF_MAX_BITS");
      end
      if (MAX_BYTES < 1 || CNT_W < $clog2(MAX_BYTES + 1)) begin : g_bad_cnt
         $error("ovs_frame_rx: MAX_BYTES or CNT_W out of range");
      end
      if (DATA_W < 1 || GAP_MAX < 1) begin : g_bad_misc
         $error("ovs_frame_rx: DATA_W and GAP_MAX must be positive");
      end
   endgenerate

   rx_state_t st_q, st_d;

   logic pos_clr, pos_adv, mid;
   logic bitc_clr, bitc_inc;
   logic [BIT_W-1:0] bitc_q;
   logic [BIT_W:0]   bitc_nxt;
   logic gap_clr, gap_inc;
   logic [GAP_W-1:0] gap_q;
   logic [GAP_W:0]   gap_nxt;
   logic sh_clr, sh_shift;
   logic [CHAR_BITS-1:0] word_nxt;
   logic [CNT_W:0]   cnt_nxt;
   logic cnt_clr, cnt_inc;
   logic bv_d, done_d, err_d;

   ovs_phase_ctr #(.OSR(OSR), .SAMPLE_POS(SAMPLE_POS)) phase_i (
      .clk(clk), .rst_n(rst_n), .clr(pos_clr), .adv(pos_adv), .mid(mid)
   );

   ovs_sat_ctr #(.W(BIT_W)) bitc_i (
      .clk(clk), .rst_n(rst_n), .clr(bitc_clr), .inc(bitc_inc), .q(bitc_q)
   );

   ovs_sat_ctr #(.W(GAP_W)) gap_i (
      .clk(clk), .rst_n(rst_n), .clr(gap_clr), .inc(gap_inc), .q(gap_q)
   );

   ovs_char_shift #(.N(CHAR_BITS)) shift_i (
      .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift(sh_shift),
      .din(rx_bit), .word_nxt(word_nxt)
   );

   assign bitc_nxt = {1'b0, bitc_q} + (BIT_W+1)'(1);
   assign gap_nxt  = {1'b0, gap_q} + (GAP_W+1)'(1);
   assign cnt_nxt  = {1'b0, byte_count} + (CNT_W+1)'(1);

   always_comb begin
      st_d     = st_q;
      pos_clr  = 1'b0;
      pos_adv  = 1'b0;
      bitc_clr = 1'b0;
      bitc_inc = 1'b0;
      gap_clr  = 1'b0;
      gap_inc  = 1'b0;
      sh_clr   = 1'b0;
      sh_shift = 1'b0;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      bv_d     = 1'b0;
      done_d   = 1'b0;
      err_d    = 1'b0;
      case (st_q)
         RX_IDLE: begin
            if (smp_en && !rx_bit) begin
               st_d     = RX_SOF;
               pos_clr  = 1'b1;
               bitc_clr = 1'b1;
            end
         end
         RX_SOF: begin
            if (smp_en) begin
               pos_adv = 1'b1;
               if (mid) begin
                  bitc_inc = 1'b1;
                  if (rx_bit) begin
                     if ({1'b0, bitc_q} >= SOF_MIN_C) begin
                        st_d    = RX_GAP;
                        gap_clr = 1'b1;
                        cnt_clr = 1'b1;
                     end else begin
                        st_d = RX_IDLE;
                     end
                  end else if (bitc_nxt > SOF_MAX_C) begin
                     st_d = RX_IDLE;
                  end
               end
            end
         end
         RX_GAP: begin
            if (smp_en) begin
               if (rx_bit) begin
                  gap_inc = 1'b1;
                  if (gap_nxt > GAP_MAX_C) begin
                     st_d  = RX_IDLE;
                     err_d = 1'b1;
                  end
               end else begin
                  st_d     = RX_CHAR;
                  pos_clr  = 1'b1;
                  bitc_clr = 1'b1;
                  sh_clr   = 1'b1;
               end
            end
         end
         RX_CHAR: begin
            if (smp_en) begin
               pos_adv = 1'b1;
               if (mid) begin
                  sh_shift = 1'b1;
                  bitc_inc = 1'b1;
                  if (bitc_nxt == CHAR_C) begin
                     if (word_nxt[CHAR_BITS-1] && !word_nxt[0]) begin
                        bv_d    = 1'b1;
                        cnt_inc = 1'b1;
                        if (cnt_nxt >= MAX_BYTE_C) begin
                           st_d  = RX_IDLE;
                           err_d = 1'b1;
                        end else begin
                           st_d    = RX_GAP;
                           gap_clr = 1'b1;
                        end
                     end else if (word_nxt == '0) begin
                        st_d   = RX_IDLE;
                        done_d = (byte_count != '0);
                     end else begin
                        st_d  = RX_IDLE;
                        err_d = 1'b1;
                     end
                  end
               end
            end
         end
         default: st_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         byte_data  <= '0;
         byte_valid <= 1'b0;
         frame_done <= 1'b0;
         frame_err  <= 1'b0;
         byte_count <= '0;
      end else begin
         st_q       <= st_d;
         byte_valid <= bv_d;
         frame_done <= done_d;
         frame_err  <= err_d;
         if (bv_d)         byte_data  <= word_nxt[CHAR_BITS-2:1];
         if (cnt_clr)      byte_count <= '0;
         else if (cnt_inc) byte_count <= cnt_nxt[CNT_W-1:0];
      end
   end

   assign in_frame = (st_q == RX_GAP) || (st_q == RX_CHAR);

endmodule

// File: rtl/ovs_frame_rx_chk.sv
module ovs_frame_rx_chk #(
   parameter int MAX_BYTES = 16,
   parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_en,
   input logic             byte_valid,
   input logic [CNT_W-1:0] byte_count,
   input logic             frame_done,
   input logic             frame_err,
   input logic             in_frame
);
   assert_quiet_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> (!byte_valid && !frame_done && !frame_err &&
                   $stable(in_frame) && $stable(byte_count)));

   assert_sof_clears_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_frame) |-> (byte_count == '0));

   assert_byte_bumps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (byte_count != $past(byte_count)));

   assert_done_closes_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!in_frame && byte_count != '0 && !frame_err));

   assert_err_closes_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !in_frame);

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      byte_count <= CNT_W'(MAX_BYTES));
endmodule

bind ovs_frame_rx ovs_frame_rx_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .byte_valid(byte_valid),
   .byte_count(byte_count), .frame_done(frame_done), .frame_err(frame_err),
   .in_frame(in_frame)
);

// File: tb/ovs_frame_rx_tb_top.sv
module ovs_frame_rx_tb_top;
   localparam int MAXB  = 3;
   localparam int CNT_W = $clog2(MAXB + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_en = 1'b0;
   logic rx_bit = 1'b1;
   logic [7:0]       byte_data;
   logic             byte_valid;
   logic [CNT_W-1:0] byte_count;
   logic             frame_done, frame_err, in_frame;

   always #10 clk = ~clk;   // 50 MHz

   ovs_frame_rx #(.MAX_BYTES(MAXB)) dut_i (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rx_bit(rx_bit),
      .byte_data(byte_data), .byte_valid(byte_valid), .byte_count(byte_count),
      .frame_done(frame_done), .frame_err(frame_err), .in_frame(in_frame)
   );

   int n_chk = 0, n_fail = 0;
   int ncap = 0, n_done = 0, n_err = 0;
   logic seen_frame = 1'b0;
   logic [7:0] cap [8];
   int cyc = 0;
   logic finished = 1'b0;

   // output monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid) begin
            if (ncap < 8) cap[ncap] = byte_data;
            ncap = ncap + 1;
         end
         if (frame_done) n_done = n_done + 1;
         if (frame_err)  n_err  = n_err + 1;
         if (in_frame)   seen_frame = 1'b1;
      end
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      ncap = 0; n_done = 0; n_err = 0; seen_frame = 1'b0;
   endtask

   // one enabled sample; the disabled cycle carries the opposite level (R2)
   task automatic smp(input logic b);
      @(negedge clk);
      rx_bit = b; smp_en = 1'b1;
      @(negedge clk);
      smp_en = 1'b0; rx_bit = ~b;
   endtask

   task automatic bitp(input logic b);
      for (int k = 0; k < 4; k++) smp(b);
   endtask

   // only position 2 carries the true value (R3)
   task automatic bit_glitch(input logic b);
      smp(~b); smp(~b); smp(b); smp(~b);
   endtask

   task automatic idle(input int nbits);
      for (int k = 0; k < nbits; k++) bitp(1'b1);
   endtask

   task automatic send_sof(input int nlow, input int extra_high);
      for (int k = 0; k < nlow; k++) bitp(1'b0);
      for (int k = 0; k < 1 + extra_high; k++) bitp(1'b1);
   endtask

   task automatic send_char(input logic [7:0] d, input logic stopb, input logic glitch);
      bitp(1'b0);
      for (int k = 0; k < 8; k++) begin
         if (glitch) bit_glitch(d[k]);
         else        bitp(d[k]);
      end
      bitp(stopb);
   endtask

   task automatic send_eof();
      for (int k = 0; k < 10; k++) bitp(1'b0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 in_frame in reset", int'(in_frame), 0);
      chk("R1 pulses in reset", int'(byte_valid | frame_done | frame_err), 0);
      chk("R1 count in reset", int'(byte_count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 in_frame after reset", int'(in_frame), 0);
   endtask

   task automatic t_basic();
      clear_mon();
      idle(2); send_sof(10, 0);
      send_char(8'hA5, 1'b1, 1'b0);
      send_char(8'h3C, 1'b1, 1'b0);
      send_eof(); idle(3);
      chk("R8 byte count seen", ncap, 2);
      chk("R8 first byte", int'(cap[0]), 8'hA5);
      chk("R8 second byte", int'(cap[1]), 8'h3C);
      chk("R9 done pulse", n_done, 1);
      chk("R2 no error with off-cycle noise", n_err, 0);
      chk("R9 count held after done", int'(byte_count), 2);
      chk("R9 in_frame dropped", int'(in_frame), 0);
   endtask

   task automatic t_long_sof_gap_edge();
      clear_mon();
      idle(2); send_sof(12, 6);
      send_char(8'h81, 1'b1, 1'b0);
      send_eof(); idle(3);
      chk("R4 twelve low bits accepted", int'(seen_frame), 1);
      chk("R7 gap of 25 samples tolerated", n_err, 0);
      chk("R4 count restarted at new frame", int'(byte_count), 1);
      chk("R8 byte after long sof", int'(cap[0]), 8'h81);
   endtask

   task automatic t_short_sof();
      clear_mon();
      idle(2); send_sof(9, 4); idle(2);
      chk("R5 nine low bits rejected", int'(seen_frame), 0);
      chk("R5 no error on reject", n_err, 0);
   endtask

   task automatic t_long_low();
      clear_mon();
      idle(2); send_sof(13, 4); idle(2);
      chk("R6 thirteen low bits give up", int'(seen_frame), 0);
      chk("R6 no error on give up", n_err, 0);
   endtask

   task automatic t_gap_timeout();
      clear_mon();
      idle(2); send_sof(10, 7); idle(2);
      chk("R7 frame had opened", int'(seen_frame), 1);
      chk("R7 gap over 25 aborts", n_err, 1);
      chk("R7 in_frame dropped", int'(in_frame), 0);
   endtask

   task automatic t_bad_stop();
      clear_mon();
      idle(2); send_sof(10, 0);
      send_char(8'h5A, 1'b0, 1'b0); idle(3);
      chk("R10 bad stop bit error", n_err, 1);
      chk("R10 no byte delivered", ncap, 0);
      chk("R10 no done", n_done, 0);
   endtask

   task automatic t_empty_eof();
      clear_mon();
      idle(2); send_sof(10, 0); send_eof(); idle(3);
      chk("R9 empty frame no done", n_done, 0);
      chk("R9 empty frame no error", n_err, 0);
      chk("R9 empty frame closed", int'(in_frame), 0);
   endtask

   task automatic t_max_bytes();
      clear_mon();
      idle(2); send_sof(10, 0);
      send_char(8'h11, 1'b1, 1'b0);
      send_char(8'h22, 1'b1, 1'b0);
      send_char(8'h33, 1'b1, 1'b0);
      idle(3);
      chk("R11 last byte delivered", ncap, 3);
      chk("R11 third byte value", int'(cap[2]), 8'h33);
      chk("R11 limit aborts", n_err, 1);
      chk("R11 count at limit", int'(byte_count), MAXB);
      chk("R11 frame closed", int'(in_frame), 0);
   endtask

   task automatic t_mid_sample();
      clear_mon();
      idle(2); send_sof(11, 0);
      send_char(8'h6B, 1'b1, 1'b1);
      send_eof(); idle(3);
      chk("R3 glitched samples ignored", int'(cap[0]), 8'h6B);
      chk("R3 frame completes", n_done, 1);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_long_sof_gap_edge();
      t_short_sof();
      t_long_low();
      t_gap_timeout();
      t_bad_stop();
      t_empty_eof();
      t_max_bytes();
      t_mid_sample();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule